// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is the recovery watchdog of an 8051-style core. It listens on the core's register-write port and stays dormant after reset. It is armed only by a fixed two-byte key written to one register address: first 0x1E, then 0xE1. Once armed, it counts machine cycles. It makes these cycles itself by dividing the oscillator clock by twelve. If software does not write the key pair again before the counter wraps, the block drives a reset pulse whose length is a fixed number of oscillator periods.

Software has no way to disarm the watchdog. Writing the key pair again only clears the count. The watchdog is disarmed only by a hardware reset: the synchronous block reset, or the external reset pin held high for longer than two machine cycles. Shorter pulses on that pin are ignored.

Top module: `keyed_wdt`

## Requirements
- R1: After the synchronous reset `rst`, `armed` is 0 and `wdt_rst` is 0.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to address 0xA6, sets `armed` to 1 from the clock after the second write.
- R3: A write to 0xA6 whose byte is not the expected next key byte aborts the sequence. A later 0x1E starts a new sequence, so the bytes 0x1E, 0x1E, 0xE1 arm the block.
- R4: Writes to any address other than 0xA6 neither advance nor abort the key sequence.
- R5: While disarmed, the counter does not advance and `wdt_rst` stays 0.
- R6: While armed, the counter advances once every 12 clock cycles. The pulse starts in the clock after the 2^CNT_W-th machine-cycle tick that follows the latest key pair. With the default width of 14 bits, this is 16384 machine cycles.
- R7: A timeout holds `wdt_rst` at 1 for exactly 96 clock cycles.
- R8: Writing the key pair again while armed clears the counter to zero, which postpones the next timeout.
- R9: While armed, no write (any address, any byte) clears `armed`.
- R10: `ext_rst_pin` clears `armed`, the counter and the key sequence once it has been sampled high on 25 consecutive clocks. Shorter high pulses have no effect.
- R11: The counter restarts from zero when it wraps and the pulse begins. While the block stays armed, timeouts therefore repeat every 2^CNT_W machine cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_pin | input | 1 | External reset pin level, qualified by hold time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| armed | output | 1 | Watchdog enable state |
| wdt_rst | output | 1 | Stretched timeout reset pulse |

## Verification
The bench builds the block with a 6-bit counter and keeps the divide-by-12 prescaler and the 96-clock pulse at their defaults. One timeout period is then 768 clocks instead of about 196 thousand. This brings exact key-to-pulse delays, back-to-back periodic timeouts and re-keying in the middle of a period within reach of a short run. The 24-clock and 25-clock pin holds probe the qualifier on both sides of its threshold.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    KS_IDLE,
    KS_HALF
  } key_state_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  a_r6_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);
endmodule

// File: rtl/wdt_rst_qualifier.sv
module wdt_rst_qualifier #(
  parameter int HOLD = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic hw_rst
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] SAT = HW'(HOLD - 1);

  logic [HW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst || !pin)    held <= '0;
    else if (held != SAT) held <= held + 1'b1;
  end

  assign hw_rst = pin && (held == SAT);

  // R10: a low pin never yields a qualified reset
  a_r10_low_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    !pin |=> !hw_rst);
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A    = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B    = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_hit
);
  key_state_t state;
  logic       hit_addr;

  assign hit_addr = wr_en && (wr_addr == KEY_ADDR);
  assign key_hit  = hit_addr && (state == KS_HALF) && (wr_data == KEY_B) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)    state <= KS_IDLE;
    else if (hit_addr) state <= (wr_data == KEY_A) ? KS_HALF : KS_IDLE;
  end

  // R3: a foreign byte at the key address drops back to idle
  a_r3_abort: assert property (@(posedge clk) disable iff (rst)
    (hit_addr && wr_data != KEY_A) |=> state == KS_IDLE);
  // R4: other addresses leave the sequence untouched
  a_r4_other_addr: assert property (@(posedge clk) disable iff (rst)
    (!hit_addr && !clr) |=> $stable(state));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic restart,
  input  logic tick,
  output logic armed,
  output logic ovf
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   armed <= 1'b0;
    else if (restart) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || restart) cnt <= '0;
    else if (armed && tick)    cnt <= cnt + 1'b1;
  end

  assign ovf = armed && tick && (cnt == TOP) && !clr && !restart;

  a_r2_key_arms: assert property (@(posedge clk) disable iff (rst)
    (restart && !clr) |=> armed);
  a_r9_no_soft_disarm: assert property (@(posedge clk) disable iff (rst)
    (armed && !clr) |=> armed);
  a_r10_hw_disarms: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!armed && cnt == '0));
  a_r5_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    !armed |=> cnt == '0);
  a_r11_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ovf |=> cnt == '0);
  a_r8_rekey_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      pulse <= 1'b0;
    end else if (fire) begin
      left  <= LW'(LEN - 1);
      pulse <= 1'b1;
    end else if (left != '0) begin
      left  <= left - 1'b1;
    end else begin
      pulse <= 1'b0;
    end
  end

  a_r6_fire_starts: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse);
  a_r7_holds_while_left: assert property (@(posedge clk) disable iff (rst)
    (pulse && left != '0) |=> pulse);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 14,
  parameter int OSC_PER_CYC = 12,
  parameter int PULSE_LEN   = 96,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A    = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B    = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              armed,
  output logic              wdt_rst
);
  localparam int HOLD_CLKS = 2 * OSC_PER_CYC + 1;

  logic tick, hw_rst, key_hit, ovf;

  wdt_prescaler #(.DIV(OSC_PER_CYC)) u_pre (
    .clk(clk), .rst(rst), .tick(tick));

  wdt_rst_qualifier #(.HOLD(HOLD_CLKS)) u_qual (
    .clk(clk), .rst(rst), .pin(ext_rst_pin), .hw_rst(hw_rst));

  wdt_key_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
                .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst(rst), .clr(hw_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .key_hit(key_hit));

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(hw_rst), .restart(key_hit), .tick(tick),
    .armed(armed), .ovf(ovf));

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(ovf), .pulse(wdt_rst));

  // R5: a disarmed block never begins a pulse
  a_r5_no_fire_disarmed: assert property (@(posedge clk) disable iff (rst)
    (!armed && !wdt_rst) |=> !wdt_rst);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CW   = 6;
  localparam int DIV  = 12;
  localparam int PLEN = 96;
  localparam int PERIOD_CLKS = (1 << CW) * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic armed, wdt_rst;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0;

  // behavioural reference state
  int m_pre = 0, m_half = 0, m_en = 0, m_cnt = 0, m_pulse = 0, m_hold = 0;

  always #10 clk = ~clk;

  keyed_wdt #(.CNT_W(CW), .OSC_PER_CYC(DIV), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst(rst), .ext_rst_pin(pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .armed(armed), .wdt_rst(wdt_rst));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    bit tick, hw, hit, ovf;
    cyc++;
    started = 1;
    ovf = 0;
    if (rst) begin
      m_pre = 0; m_half = 0; m_en = 0; m_cnt = 0; m_pulse = 0; m_hold = 0;
    end else begin
      tick = (m_pre == DIV - 1);
      m_pre = tick ? 0 : m_pre + 1;
      hw = pin && (m_hold == 2 * DIV);
      m_hold = !pin ? 0 : (m_hold < 2 * DIV ? m_hold + 1 : m_hold);
      hit = wr_en && wr_addr == 8'hA6 && m_half == 1 && wr_data == 8'hE1 && !hw;
      if (hw) begin
        m_half = 0; m_en = 0; m_cnt = 0;
      end else begin
        if (wr_en && wr_addr == 8'hA6) m_half = (wr_data == 8'h1E) ? 1 : 0;
        if (hit) begin
          m_en = 1; m_cnt = 0;
        end else if (m_en == 1 && tick) begin
          ovf = (m_cnt == (1 << CW) - 1);
          m_cnt = (m_cnt + 1) % (1 << CW);
        end
      end
      if (ovf) m_pulse = PLEN;
      else if (m_pulse > 0) m_pulse--;
    end
    if (cyc > 60000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
      finish_up();
    end
  end

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(armed == (m_en == 1), "R2/R9 armed", int'(armed), m_en);
      chk(wdt_rst == (m_pulse > 0), "R6/R7 wdt_rst", int'(wdt_rst), int'(m_pulse > 0));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output int at);
    while (!wdt_rst) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    int k, r1, r2, w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(armed == 1'b0, "R1 armed after reset", int'(armed), 0);
    chk(wdt_rst == 1'b0, "R1 pulse after reset", int'(wdt_rst), 0);

    idle(PERIOD_CLKS + 50);
    chk(wdt_rst == 1'b0, "R5 no pulse disarmed", int'(wdt_rst), 0);

    // R3: lone second byte, then an aborted pair
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h33); wr(8'hA6, 8'hE1);
    idle(2);
    chk(armed == 1'b0, "R3 abort", int'(armed), 0);

    // R4: foreign writes between key bytes
    wr(8'hA6, 8'h1E); wr(8'hA5, 8'hE1); wr(8'h80, 8'h00);
    chk(armed == 1'b0, "R4 other addr no arm", int'(armed), 0);
    wr(8'hA6, 8'hE1);
    chk(armed == 1'b1, "R2 key arms", int'(armed), 1);

    // R10: 24-clock pin hold ignored, 25-clock hold disarms
    pin = 1'b1; idle(24); pin = 1'b0; idle(1);
    chk(armed == 1'b1, "R10 short hold ignored", int'(armed), 1);
    pin = 1'b1; idle(25); pin = 1'b0; idle(1);
    chk(armed == 1'b0, "R10 long hold disarms", int'(armed), 0);

    // R3: restart with a repeated first byte
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    chk(armed == 1'b1, "R3 restart arms", int'(armed), 1);

    // R9: software writes cannot disarm
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'h87, 8'h00);
    idle(2);
    chk(armed == 1'b1, "R9 no soft disarm", int'(armed), 1);

    // R8: rekey halfway through the period
    idle(PERIOD_CLKS / 2);
    chk(wdt_rst == 1'b0, "R8 no early pulse", int'(wdt_rst), 0);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    k = cyc;
    wait_rise(r1);
    chk((r1 - k) >= PERIOD_CLKS - DIV + 1 && (r1 - k) <= PERIOD_CLKS,
        "R6/R8 key to pulse delay", r1 - k, PERIOD_CLKS);

    // R7: pulse width
    w = 0;
    while (wdt_rst) begin w++; @(negedge clk); end
    chk(w == PLEN, "R7 pulse width", w, PLEN);

    // R11: periodic timeouts
    wait_rise(r2);
    chk(r2 - r1 == PERIOD_CLKS, "R11 period", r2 - r1, PERIOD_CLKS);
    chk(armed == 1'b1, "R11 still armed", int'(armed), 1);

    // R1: reset mid-pulse clears everything
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(armed == 1'b0 && wdt_rst == 1'b0, "R1 reset clears", int'(armed), 0);

    done = 1;
    finish_up();
  end
endmodule